// File: doc/BRIEF.md
# Phase-Qualified Address Decoder for a Two-Phase Processor Bus

This block is the glue logic between a two-phase-clock processor that multiplexes its top address byte onto the data bus and four memory-mapped devices: a ROM, two RAMs and a parallel I/O peripheral. While phase 2 is low, the processor places the bank byte on the data bus. The block holds that byte in a transparent latch that closes when phase 2 rises. It combines the latched bank with the 16-bit low address to form a full 24-bit address and decodes it into four active-high chip selects.

Every select is masked unless one of the processor's two valid-address flags is high, so no device is enabled while the address lines are still moving between cycles. The RAM selects are further ANDed with phase 2, so a RAM cannot see a write before the address has settled.

The peripheral and ROM selects are not gated by phase 2. They assert in the low phase, because the peripheral needs its select and direction line stable before phase 2 rises; it takes write data on the falling edge. An active-low write strobe is also produced, asserted only while phase 2 is high during a write. The RAM phase gating is fixed at elaboration time by a parameter; the default gates the selects themselves.

Top module: `busgate_decode`

## Requirements
- R1: `pio_cs` is high for low addresses 0xDDE0 to 0xDDE3 in bank 0 during a valid cycle, in both the low and the high phase of phase 2.
- R2: In bank 0 during a valid cycle, `ram0_cs` is high for 0x0000 to 0x7FFF and `ram1_cs` is high for 0x8000 to 0xDDDF (address bit 15 splits the two). Both are high only while `phi2` is high.
- R3: `rom_cs` is high for low addresses 0xE000 to 0xFFFF in bank 0 during a valid cycle, in both phases.
- R4: When `vda` and `vpa` are both low, no chip select is high, whatever the address.
- R5: A nonzero bank byte selects nothing. Low addresses 0xDDE4 to 0xDFFF in bank 0 also select nothing.
- R6: At most one chip select is high at any time.
- R7: `bank_q` follows `data` while `phi2` is low, keeps its value while `phi2` is high, and is 0 while `rst_n` is low.
- R8: `wr_n` is low exactly when `rw` is low and `phi2` is high.
- R9: Either `vda` alone or `vpa` alone marks a cycle as valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Active-low reset; clears the bank latch |
| phi2 | input | 1 | Phase-2 clock of the processor |
| rw | input | 1 | Direction: 1 read, 0 write |
| vda | input | 1 | Valid data address flag |
| vpa | input | 1 | Valid program address flag |
| addr | input | 16 | Low 16 address bits |
| data | input | 8 | Data bus; carries the bank byte while phi2 is low |
| rom_cs | output | 1 | ROM select, active high |
| ram0_cs | output | 1 | Lower RAM select, active high |
| ram1_cs | output | 1 | Upper RAM select, active high |
| pio_cs | output | 1 | Peripheral select, active high |
| wr_n | output | 1 | Phase-gated write strobe, active low |
| bank_q | output | 8 | Latched bank byte |

## Verification
The bench checks each select in both phases of the same bus cycle.

- A decoder that forgot the phase gate would raise a RAM select in the low phase, where the address may still be moving.
- A decoder that gated the peripheral with phase 2 would raise its select too late, after the peripheral needs it.

The edges of each window are exercised: 0x7FFF against 0x8000, 0xDDDF against 0xDDE0, 0xDDE3 against 0xDDE4, and 0xDFFF against 0xE000. An off-by-one in any of these would either open a hole or make two selects overlap. The complete bank-0 address space is then swept against an independent model.

Three further cases are covered. Data is changed during the high phase, which exposes a bank latch that stays open after phase 2 rises. Nonzero banks must select nothing. Cycles with no valid flag must select nothing.

// File: rtl/busgate_pkg.sv
package busgate_pkg;
   // device slots in the select vector
   localparam int DEV_N    = 4;
   localparam int DEV_ROM  = 0;
   localparam int DEV_RAM0 = 1;
   localparam int DEV_RAM1 = 2;
   localparam int DEV_PIO  = 3;

   // slots that hold memory which must wait for phase 2
   localparam logic [DEV_N-1:0] RAM_MASK = 4'b0110;

   // how phase 2 protects the RAMs
   typedef enum logic [0:0] {
      GATE_SELECT = 1'b1,
      GATE_STROBE = 1'b0
   } ram_gate_e;
endpackage

// File: rtl/bg_bank_latch.sv
module bg_bank_latch #(
   parameter int BANK_W = 8
) (
   input  logic              rst_n,
   input  logic              phi2,
   input  logic [BANK_W-1:0] data,
   output logic [BANK_W-1:0] bank_q
);
   // open while phase 2 is low, closed while it is high
   always_latch begin
      if (!rst_n)
         bank_q = '0;
      else if (!phi2)
         bank_q = data;
   end
endmodule

// File: rtl/bg_region_decode.sv
module bg_region_decode
   import busgate_pkg::*;
#(
   parameter int          ADDR_W        = 16,
   parameter int          BANK_W        = 8,
   parameter int unsigned PIO_BASE      = 32'hDDE0,
   parameter int unsigned PIO_SPAN      = 4,
   parameter int unsigned ROM_BASE      = 32'hE000,
   parameter int          RAM_SPLIT_BIT = 15
) (
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] addr,
   output logic [DEV_N-1:0]  hit
);
   localparam int              PIO_AW = (PIO_SPAN > 1) ? $clog2(PIO_SPAN) : 0;
   localparam logic [ADDR_W-1:0] PIO_A = PIO_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] ROM_A = ROM_BASE[ADDR_W-1:0];

   logic in_bank0;
   logic pio_win;

   assign in_bank0 = (bank == '0);
   assign pio_win  = (addr[ADDR_W-1:PIO_AW] == PIO_A[ADDR_W-1:PIO_AW]);

   // priority chain gives a one-hot result by construction
   always_comb begin
      hit = '0;
      if (in_bank0) begin
         if (addr >= ROM_A)
            hit[DEV_ROM] = 1'b1;
         else if (pio_win)
            hit[DEV_PIO] = 1'b1;
         else if (addr < PIO_A) begin
            if (addr[RAM_SPLIT_BIT])
               hit[DEV_RAM1] = 1'b1;
            else
               hit[DEV_RAM0] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/bg_select_qualify.sv
module bg_select_qualify
   import busgate_pkg::*;
#(
   parameter ram_gate_e RAM_GATE = GATE_SELECT
) (
   input  logic             phi2,
   input  logic             rw,
   input  logic             vda,
   input  logic             vpa,
   input  logic [DEV_N-1:0] hit,
   output logic [DEV_N-1:0] sel,
   output logic             wr_n
);
   logic cyc_ok;
   assign cyc_ok = vda | vpa;

   for (genvar i = 0; i < DEV_N; i++) begin : gen_dev
      if (RAM_MASK[i] && (RAM_GATE == GATE_SELECT)) begin : g_phase
         assign sel[i] = hit[i] & cyc_ok & phi2;
      end else begin : g_early
         assign sel[i] = hit[i] & cyc_ok;
      end
   end

   // the strobe is always phase gated; with GATE_STROBE it alone protects RAM
   assign wr_n = ~(~rw & phi2);
endmodule

// File: rtl/busgate_decode.sv
module busgate_decode
   import busgate_pkg::*;
#(
   parameter int          ADDR_W        = 16,
   parameter int          BANK_W        = 8,
   parameter int unsigned PIO_BASE      = 32'hDDE0,
   parameter int unsigned PIO_SPAN      = 4,
   parameter int unsigned ROM_BASE      = 32'hE000,
   parameter int          RAM_SPLIT_BIT = 15,
   parameter ram_gate_e   RAM_GATE      = GATE_SELECT
) (
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              rw,
   input  logic              vda,
   input  logic              vpa,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BANK_W-1:0] data,
   output logic              rom_cs,
   output logic              ram0_cs,
   output logic              ram1_cs,
   output logic              pio_cs,
   output logic              wr_n,
   output logic [BANK_W-1:0] bank_q
);
   // elaboration-time parameter checks
   if ((PIO_SPAN == 0) || ((PIO_SPAN & (PIO_SPAN - 1)) != 0)) begin : g_chk_span
      $error("PIO_SPAN must be a nonzero power of two");
   end
   if ((PIO_BASE % PIO_SPAN) != 0) begin : g_chk_align
      $error("PIO_BASE must be aligned to PIO_SPAN");
   end
   if (PIO_BASE + PIO_SPAN > ROM_BASE) begin : g_chk_order
      $error("peripheral window must lie below the ROM");
   end
   if (ROM_BASE >= (64'd1 << ADDR_W)) begin : g_chk_rom
      $error("ROM_BASE outside the low address space");
   end
   if ((RAM_SPLIT_BIT < 0) || (RAM_SPLIT_BIT >= ADDR_W)) begin : g_chk_split
      $error("RAM_SPLIT_BIT outside the address width");
   end

   logic [DEV_N-1:0] hit;
   logic [DEV_N-1:0] sel;

   bg_bank_latch #(
      .BANK_W (BANK_W)
   ) u_latch (
      .rst_n  (rst_n),
      .phi2   (phi2),
      .data   (data),
      .bank_q (bank_q)
   );

   bg_region_decode #(
      .ADDR_W        (ADDR_W),
      .BANK_W        (BANK_W),
      .PIO_BASE      (PIO_BASE),
      .PIO_SPAN      (PIO_SPAN),
      .ROM_BASE      (ROM_BASE),
      .RAM_SPLIT_BIT (RAM_SPLIT_BIT)
   ) u_region (
      .bank (bank_q),
      .addr (addr),
      .hit  (hit)
   );

   bg_select_qualify #(
      .RAM_GATE (RAM_GATE)
   ) u_qual (
      .phi2 (phi2),
      .rw   (rw),
      .vda  (vda),
      .vpa  (vpa),
      .hit  (hit),
      .sel  (sel),
      .wr_n (wr_n)
   );

   assign rom_cs  = sel[DEV_ROM];
   assign ram0_cs = sel[DEV_RAM0];
   assign ram1_cs = sel[DEV_RAM1];
   assign pio_cs  = sel[DEV_PIO];
endmodule

// File: rtl/busgate_decode_chk.sv
module busgate_decode_chk #(
   parameter int          ADDR_W   = 16,
   parameter int          BANK_W   = 8,
   parameter int unsigned PIO_BASE = 32'hDDE0,
   parameter int unsigned PIO_SPAN = 4,
   parameter int unsigned ROM_BASE = 32'hE000
) (
   input logic              rst_n,
   input logic              phi2,
   input logic              rw,
   input logic              vda,
   input logic              vpa,
   input logic [ADDR_W-1:0] addr,
   input logic [BANK_W-1:0] data,
   input logic              rom_cs,
   input logic              ram0_cs,
   input logic              ram1_cs,
   input logic              pio_cs,
   input logic              wr_n,
   input logic [BANK_W-1:0] bank_q
);
   localparam int              PAW   = $clog2(PIO_SPAN);
   localparam logic [ADDR_W-1:0] PIO_A = PIO_BASE[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] ROM_A = ROM_BASE[ADDR_W-1:0];

   logic any_cs;
   assign any_cs = rom_cs | ram0_cs | ram1_cs | pio_cs;

   // sampled at the rise: values from the end of the low phase
   p_ram_wait_phi2_r2: assert property (@(posedge phi2) disable iff (!rst_n)
      !(ram0_cs || ram1_cs));

   p_pio_early_r1: assert property (@(posedge phi2) disable iff (!rst_n)
      ((vda || vpa) && bank_q == '0 && addr[ADDR_W-1:PAW] == PIO_A[ADDR_W-1:PAW]) |-> pio_cs);

   p_rom_early_r3: assert property (@(posedge phi2) disable iff (!rst_n)
      ((vda || vpa) && bank_q == '0 && addr >= ROM_A) |-> rom_cs);

   p_invalid_idle_r4: assert property (@(negedge phi2) disable iff (!rst_n)
      !(vda || vpa) |-> !any_cs);

   p_bank_unmapped_r5: assert property (@(negedge phi2) disable iff (!rst_n)
      (bank_q != '0) |-> !any_cs);

   p_onehot_hi_r6: assert property (@(negedge phi2) disable iff (!rst_n)
      $onehot0({rom_cs, ram0_cs, ram1_cs, pio_cs}));

   p_onehot_lo_r6: assert property (@(posedge phi2) disable iff (!rst_n)
      $onehot0({rom_cs, ram0_cs, ram1_cs, pio_cs}));

   p_bank_follow_r7: assert property (@(posedge phi2) disable iff (!rst_n)
      bank_q == data);

   p_strobe_idle_r8: assert property (@(posedge phi2) disable iff (!rst_n)
      wr_n);

   p_strobe_write_r8: assert property (@(negedge phi2) disable iff (!rst_n)
      !rw |-> !wr_n);
endmodule

bind busgate_decode busgate_decode_chk u_chk (.*);

// File: tb/busgate_decode_bench.sv
`timescale 1ns/1ps
module busgate_decode_bench;
   logic       rst_n = 1'b0;
   logic       phi2  = 1'b0;
   logic       rw    = 1'b1;
   logic       vda   = 1'b0;
   logic       vpa   = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [7:0]  data = 8'h00;
   logic rom_cs, ram0_cs, ram1_cs, pio_cs, wr_n;
   logic [7:0] bank_q;

   int checks = 0;
   int errors = 0;

   always #2.5 phi2 = ~phi2;   // 200 MHz

   busgate_decode u_busgate_decode (
      .rst_n (rst_n), .phi2 (phi2), .rw (rw), .vda (vda), .vpa (vpa),
      .addr (addr), .data (data), .rom_cs (rom_cs), .ram0_cs (ram0_cs),
      .ram1_cs (ram1_cs), .pio_cs (pio_cs), .wr_n (wr_n), .bank_q (bank_q)
   );

   // select vector order: {pio, ram1, ram0, rom}
   function automatic logic [3:0] sel_now();
      return {pio_cs, ram1_cs, ram0_cs, rom_cs};
   endfunction

   // independent model of the memory map
   function automatic logic [3:0] model(input logic [7:0] b, input logic [15:0] a,
                                        input logic ok, input logic hi);
      if (!ok || b != 8'h00) return 4'b0000;
      if (a >= 16'hE000) return 4'b0001;
      if (a >= 16'hDDE0 && a <= 16'hDDE3) return 4'b1000;
      if (a <= 16'h7FFF) return hi ? 4'b0010 : 4'b0000;
      if (a <= 16'hDDDF) return hi ? 4'b0100 : 4'b0000;
      return 4'b0000;
   endfunction

   function automatic string tag_of(input logic [7:0] b, input logic [15:0] a, input logic ok);
      if (!ok) return "R4";
      if (b != 8'h00) return "R5";
      if (a >= 16'hE000) return "R3";
      if (a >= 16'hDDE0 && a <= 16'hDDE3) return "R1";
      if (a <= 16'hDDDF) return "R2";
      return "R5";
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h expected %h (addr %h bank_q %h)", req, got, exp, addr, bank_q);
      end
   endtask

   // {bank, addr, vda, vpa, rw, low-phase sel, high-phase sel}
   localparam int NV = 16;
   localparam logic [34:0] VEC [NV] = '{
      {8'h00, 16'h0000, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0010},
      {8'h00, 16'h7FFF, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0010},
      {8'h00, 16'h8000, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b0100},
      {8'h00, 16'hDDDF, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0100},
      {8'h00, 16'hDDE0, 1'b1, 1'b0, 1'b0, 4'b1000, 4'b1000},
      {8'h00, 16'hDDE3, 1'b0, 1'b1, 1'b1, 4'b1000, 4'b1000},
      {8'h00, 16'hDDE4, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0000},
      {8'h00, 16'hDFFF, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000},
      {8'h00, 16'hE000, 1'b0, 1'b1, 1'b1, 4'b0001, 4'b0001},
      {8'h00, 16'hFFFC, 1'b1, 1'b0, 1'b1, 4'b0001, 4'b0001},
      {8'h00, 16'hDDE1, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000},
      {8'h00, 16'h1234, 1'b0, 1'b0, 1'b0, 4'b0000, 4'b0000},
      {8'h01, 16'hE000, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b0000},
      {8'hFF, 16'h0100, 1'b1, 1'b0, 1'b0, 4'b0000, 4'b0000},
      {8'h80, 16'hDDE2, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0000},
      {8'h00, 16'hC000, 1'b0, 1'b1, 1'b0, 4'b0000, 4'b0100}
   };

   // one bus cycle: drive in the low phase, check late in each phase;
   // in the high phase the data bus carries write data (~bank)
   task automatic bus_cycle(input logic [7:0] b, input logic [15:0] a, input logic v_d,
                            input logic v_p, input logic r, input logic [3:0] exp_lo,
                            input logic [3:0] exp_hi);
      string t;
      t = tag_of(b, a, v_d | v_p);
      @(negedge phi2);
      #0.5;
      addr = a; data = b; vda = v_d; vpa = v_p; rw = r;
      #1.5;
      check(t, {28'd0, sel_now()}, {28'd0, exp_lo});
      check("R8", {31'd0, wr_n}, 32'd1);
      check("R7", {24'd0, bank_q}, {24'd0, b});
      @(posedge phi2);
      #0.5;
      data = ~b;
      #1.5;
      check(t, {28'd0, sel_now()}, {28'd0, exp_hi});
      check("R8", {31'd0, wr_n}, {31'd0, r});
      check("R7", {24'd0, bank_q}, {24'd0, b});   // latch held despite data change
   endtask

   initial begin : watchdog
      #600us;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      // reset state: latch cleared even while the data bus toggles (R7)
      data = 8'hA5;
      repeat (3) @(posedge phi2);
      #1.0;
      check("R7", {24'd0, bank_q}, 32'd0);
      @(negedge phi2);
      #1.0;
      check("R7", {24'd0, bank_q}, 32'd0);
      check("R4", {28'd0, sel_now()}, 32'd0);
      data = 8'h00;
      #0.5;
      rst_n = 1'b1;

      // table of vectors: R1 R2 R3 R4 R5 R8 R9
      for (int i = 0; i < NV; i++) begin
         bus_cycle(VEC[i][34:27], VEC[i][26:11], VEC[i][10], VEC[i][9], VEC[i][8],
                   VEC[i][7:4], VEC[i][3:0]);
      end

      // R9: each flag alone validates the same address
      bus_cycle(8'h00, 16'h4000, 1'b0, 1'b1, 1'b1, 4'b0000, 4'b0010);
      bus_cycle(8'h00, 16'h4000, 1'b1, 1'b0, 1'b1, 4'b0000, 4'b0010);

      // R6 sweep of bank 0 against the model, one cycle per address
      for (int a = 0; a < 65536; a++) begin
         @(negedge phi2);
         #0.5;
         addr = a[15:0]; data = 8'h00; vda = 1'b1; vpa = 1'b0; rw = 1'b0;
         #1.5;
         checks++;
         if ($countones(sel_now()) > 1 || sel_now() !== model(8'h00, a[15:0], 1'b1, 1'b0)) begin
            errors++;
            $display("FAIL R6 low phase addr %h got %b expected %b", a[15:0], sel_now(),
                     model(8'h00, a[15:0], 1'b1, 1'b0));
         end
         @(posedge phi2);
         #2.0;
         checks++;
         if ($countones(sel_now()) > 1 || sel_now() !== model(8'h00, a[15:0], 1'b1, 1'b1)) begin
            errors++;
            $display("FAIL R6 high phase addr %h got %b expected %b", a[15:0], sel_now(),
                     model(8'h00, a[15:0], 1'b1, 1'b1));
         end
      end

      // R5: nonzero banks across the low address space
      for (int k = 0; k < 256; k++) begin
         bus_cycle(8'h03, {k[7:0], 8'h00}, 1'b1, 1'b1, 1'b1, 4'b0000, 4'b0000);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule